// File: doc/BRIEF.md
# Pipelined Vector Magnitude Unit

This unit takes a complex sample as two signed components and returns its length, |v| = sqrt(I² + Q²), as an unsigned 16-bit value. It never squares anything and never takes a root. It works by shift-and-add vector rotation in vectoring mode. A first stage mirrors the vector into the right half-plane. Then a chain of micro-rotations turns it toward angle zero, each stage picking its direction from the sign of the current quadrature value. The remaining in-phase value is the magnitude, multiplied by the fixed rotation gain. A final stage scales that gain out with one constant multiply, rounds to the output grid, and clamps anything that no longer fits in 16 bits.

Every stage has its own register, so the unit accepts a new sample on every clock and never stalls. A valid flag and a free-form tag travel beside the data with exactly the same delay, so the surrounding stream logic can match each result to the sample it came from. A synchronous active-high reset empties the whole pipeline.

Top module: `cordmag_top`

## Requirements
- R1: For an input whose true magnitude rounds to less than 65537, out_mag lies within ±2 of min(round(sqrt(I²+Q²)), 65535). This holds in all four quadrants and on both axes.
- R2: When round(sqrt(I²+Q²)) is 65537 or more, out_mag is exactly 65535 (all ones). This includes the corners where one or both components are -65536.
- R3: out_valid rises exactly STAGES+2 clock edges (18 with defaults) after the edge that captured in_valid high, and a result is produced for that sample and for no other.
- R4: out_tag equals the in_tag captured with the same sample, delayed by the same STAGES+2 edges.
- R5: A new sample is accepted on every clock with in_valid high, with no stall. Cycles with in_valid low produce no result, and every accepted sample yields exactly one result.
- R6: After a clock edge with rst high, out_valid, out_mag and out_tag are all zero. Samples in flight at that edge are discarded and never appear at the output.
- R7: The zero vector (I = Q = 0) gives out_mag exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on the rising edge |
| rst | input | 1 | Synchronous reset, active high, clears every stage |
| in_valid | input | 1 | Sample on in_i/in_q/in_tag is valid this cycle |
| in_i | input | 17 | In-phase component, two's complement |
| in_q | input | 17 | Quadrature component, two's complement |
| in_tag | input | 8 | Sideband tag carried with the sample |
| out_valid | output | 1 | Result on out_mag/out_tag is valid |
| out_mag | output | 16 | Unsigned rounded magnitude, clamped to 65535 |
| out_tag | output | 8 | Tag of the sample this result belongs to |

## Verification
The hardest behaviour to reach from the ports is an input that is already at the edge of the representable range: the most negative component, where the half-plane fold must grow by a bit, and magnitudes straddling the clamp threshold. Directed table entries put both components at -65536 and at 46340, close to the 16-bit limit, next to axis-aligned and mirrored small vectors. A second hard case is a reset arriving while samples are in flight. The stimulus fills the pipeline with tagged samples, pulses reset midway, and then watches a full latency window for any stray result.

// File: rtl/cordmag_pkg.sv
package cordmag_pkg;

  // Which way a micro-rotation turns the vector.
  typedef enum logic {
    ROT_DOWN = 1'b0,  // quadrature >= 0: turn clockwise
    ROT_UP   = 1'b1   // quadrature <  0: turn counter-clockwise
  } rot_dir_e;

  // Working width: sign, one bit for the fold of the most negative value,
  // one bit for the gain growth of about 2.33, plus fractional guard bits.
  function automatic int work_width(input int in_w, input int guard);
    return in_w + 3 + guard;
  endfunction

endpackage

// File: rtl/cordmag_fold.sv
module cordmag_fold #(
  parameter int IN_W  = 17,
  parameter int W     = 25,
  parameter int GUARD = 5,
  parameter int TAG_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_i,
  input  logic signed [IN_W-1:0]  in_q,
  input  logic [TAG_W-1:0]        in_tag,
  output logic                    out_valid,
  output logic signed [W-1:0]     out_x,
  output logic signed [W-1:0]     out_y,
  output logic [TAG_W-1:0]        out_tag
);

  localparam int EXT = W - IN_W;

  logic signed [W-1:0] wide_i, wide_q;
  logic signed [W-1:0] sc_i, sc_q;

  always_comb begin
    wide_i = {{EXT{in_i[IN_W-1]}}, in_i};
    wide_q = {{EXT{in_q[IN_W-1]}}, in_q};
    sc_i   = wide_i <<< GUARD;
    sc_q   = wide_q <<< GUARD;
  end

  // Negating both components turns the vector by 180 degrees: the length
  // is unchanged and the angle lands in [-90, 90].
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_tag   <= '0;
    end else begin
      out_valid <= in_valid;
      out_tag   <= in_tag;
      if (sc_i[W-1]) begin
        out_x <= -sc_i;
        out_y <= -sc_q;
      end else begin
        out_x <= sc_i;
        out_y <= sc_q;
      end
    end
  end

endmodule

// File: rtl/cordmag_stage.sv
module cordmag_stage
  import cordmag_pkg::*;
#(
  parameter int W     = 25,
  parameter int TAG_W = 8,
  parameter int SHIFT = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_x,
  input  logic signed [W-1:0] in_y,
  input  logic [TAG_W-1:0]    in_tag,
  output logic                out_valid,
  output logic signed [W-1:0] out_x,
  output logic signed [W-1:0] out_y,
  output logic [TAG_W-1:0]    out_tag
);

  rot_dir_e            dir;
  logic signed [W-1:0] x_sh, y_sh;

  always_comb begin
    dir  = in_y[W-1] ? ROT_UP : ROT_DOWN;
    x_sh = in_x >>> SHIFT;
    y_sh = in_y >>> SHIFT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_tag   <= '0;
    end else begin
      out_valid <= in_valid;
      out_tag   <= in_tag;
      if (dir == ROT_DOWN) begin
        out_x <= in_x + y_sh;
        out_y <= in_y - x_sh;
      end else begin
        out_x <= in_x - y_sh;
        out_y <= in_y + x_sh;
      end
    end
  end

endmodule

// File: rtl/cordmag_scale.sv
module cordmag_scale #(
  parameter int          W      = 25,
  parameter int          OUT_W  = 16,
  parameter int          TAG_W  = 8,
  parameter int          GUARD  = 5,
  parameter int          K_FRAC = 18,
  parameter int unsigned K_INV  = 159188
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_x,
  input  logic [TAG_W-1:0]    in_tag,
  output logic                out_valid,
  output logic [OUT_W-1:0]    out_mag,
  output logic [TAG_W-1:0]    out_tag
);

  localparam int SH = GUARD + K_FRAC;
  localparam int PW = W + K_FRAC + 1;

  logic [W-1:0]  mag_u;
  logic [PW-1:0] prod, rounded, quot;
  logic          over;

  always_comb begin
    // In the right half-plane x never goes negative; clamp defensively.
    mag_u   = in_x[W-1] ? '0 : $unsigned(in_x);
    prod    = PW'(mag_u) * PW'(K_INV);
    rounded = prod + (PW'(1) << (SH - 1));
    quot    = rounded >> SH;
    over    = |quot[PW-1:OUT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mag   <= '0;
      out_tag   <= '0;
    end else begin
      out_valid <= in_valid;
      out_tag   <= in_tag;
      out_mag   <= over ? '1 : quot[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/cordmag_top.sv
module cordmag_top
  import cordmag_pkg::*;
#(
  parameter int          IN_W   = 17,
  parameter int          OUT_W  = 16,
  parameter int          TAG_W  = 8,
  parameter int          STAGES = 16,
  parameter int          GUARD  = 5,
  parameter int          K_FRAC = 18,
  parameter int unsigned K_INV  = 159188   // round(2^K_FRAC / gain of STAGES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_i,
  input  logic signed [IN_W-1:0] in_q,
  input  logic [TAG_W-1:0]       in_tag,
  output logic                   out_valid,
  output logic [OUT_W-1:0]       out_mag,
  output logic [TAG_W-1:0]       out_tag
);

  localparam int W       = work_width(IN_W, GUARD);
  localparam int LATENCY = STAGES + 2;

  // Index k holds the operands entering rotation stage k.
  logic signed [W-1:0] xs   [STAGES+1];
  logic signed [W-1:0] ys   [STAGES];
  logic                vs   [STAGES+1];
  logic [TAG_W-1:0]    tags [STAGES+1];

  cordmag_fold #(
    .IN_W(IN_W), .W(W), .GUARD(GUARD), .TAG_W(TAG_W)
  ) u_fold (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q), .in_tag(in_tag),
    .out_valid(vs[0]), .out_x(xs[0]), .out_y(ys[0]), .out_tag(tags[0])
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_rot
    if (k < STAGES - 1) begin : g_full
      cordmag_stage #(
        .W(W), .TAG_W(TAG_W), .SHIFT(k)
      ) u_stage (
        .clk(clk), .rst(rst),
        .in_valid(vs[k]), .in_x(xs[k]), .in_y(ys[k]), .in_tag(tags[k]),
        .out_valid(vs[k+1]), .out_x(xs[k+1]), .out_y(ys[k+1]),
        .out_tag(tags[k+1])
      );
    end else begin : g_last
      // Final rotation: only the in-phase result is needed downstream.
      logic signed [W-1:0] y_sh;
      assign y_sh = ys[k] >>> k;
      always_ff @(posedge clk) begin
        if (rst) begin
          vs[k+1]   <= 1'b0;
          xs[k+1]   <= '0;
          tags[k+1] <= '0;
        end else begin
          vs[k+1]   <= vs[k];
          tags[k+1] <= tags[k];
          xs[k+1]   <= ys[k][W-1] ? xs[k] - y_sh : xs[k] + y_sh;
        end
      end
    end
  end

  cordmag_scale #(
    .W(W), .OUT_W(OUT_W), .TAG_W(TAG_W), .GUARD(GUARD),
    .K_FRAC(K_FRAC), .K_INV(K_INV)
  ) u_scale (
    .clk(clk), .rst(rst),
    .in_valid(vs[STAGES]), .in_x(xs[STAGES]), .in_tag(tags[STAGES]),
    .out_valid(out_valid), .out_mag(out_mag), .out_tag(out_tag)
  );

endmodule

// File: rtl/cordmag_chk.sv
module cordmag_chk #(
  parameter int IN_W    = 17,
  parameter int OUT_W   = 16,
  parameter int TAG_W   = 8,
  parameter int LATENCY = 18
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic signed [IN_W-1:0] in_i,
  input logic signed [IN_W-1:0] in_q,
  input logic [TAG_W-1:0]       in_tag,
  input logic                   out_valid,
  input logic [OUT_W-1:0]       out_mag,
  input logic [TAG_W-1:0]       out_tag
);

  localparam longint MAXV   = (longint'(1) << OUT_W) - 1;
  localparam longint SAT_SQ = (MAXV + 2) * (MAXV + 2);

  logic                   d_v [LATENCY];
  logic signed [IN_W-1:0] d_i [LATENCY];
  logic signed [IN_W-1:0] d_q [LATENCY];
  logic [TAG_W-1:0]       d_t [LATENCY];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LATENCY; k++) begin
        d_v[k] <= 1'b0;
        d_i[k] <= '0;
        d_q[k] <= '0;
        d_t[k] <= '0;
      end
    end else begin
      d_v[0] <= in_valid;
      d_i[0] <= in_i;
      d_q[0] <= in_q;
      d_t[0] <= in_tag;
      for (int k = 1; k < LATENCY; k++) begin
        d_v[k] <= d_v[k-1];
        d_i[k] <= d_i[k-1];
        d_q[k] <= d_q[k-1];
        d_t[k] <= d_t[k-1];
      end
    end
  end

  longint sq, m, hi_b, lo_b;
  logic   in_band;

  always_comb begin
    sq   = longint'(d_i[LATENCY-1]) * longint'(d_i[LATENCY-1])
         + longint'(d_q[LATENCY-1]) * longint'(d_q[LATENCY-1]);
    m    = longint'(out_mag);
    hi_b = (2 * m + 5) * (2 * m + 5);
    lo_b = (2 * m - 5) * (2 * m - 5);
    in_band = (4 * sq <= hi_b) && ((m < 3) || (4 * sq >= lo_b));
  end

  // R3
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == d_v[LATENCY-1]);

  // R4
  tag_delay_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_tag == d_t[LATENCY-1]));

  // R1
  mag_band_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (m < MAXV)) |-> in_band);

  // R2
  clamp_full_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (sq >= SAT_SQ)) |-> (m == MAXV));

  // R7
  zero_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (sq == 0)) |-> (out_mag == '0));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && (out_mag == '0) && (out_tag == '0)));

endmodule

bind cordmag_top cordmag_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .TAG_W(TAG_W), .LATENCY(STAGES + 2)
) i_cordmag_chk (
  .clk(clk), .rst(rst),
  .in_valid(in_valid), .in_i(in_i), .in_q(in_q), .in_tag(in_tag),
  .out_valid(out_valid), .out_mag(out_mag), .out_tag(out_tag)
);

// File: tb/test_cordmag_top.sv
module test_cordmag_top;

  localparam int IN_W   = 17;
  localparam int OUT_W  = 16;
  localparam int TAG_W  = 8;
  localparam int STAGES = 16;
  localparam int LAT    = STAGES + 2;
  localparam int MAXV   = (1 << OUT_W) - 1;
  localparam int NVEC   = 19;
  localparam int NTAG   = 1 << TAG_W;

  // {I, Q, rounded true magnitude}
  localparam int VEC [NVEC][3] = '{
    '{3, 4, 5},            '{-7, 24, 25},          '{5, -12, 13},
    '{-8, -15, 17},        '{0, 0, 0},             '{100, 0, 100},
    '{0, -100, 100},       '{-1, 0, 1},            '{1, 1, 1},
    '{-39, 80, 89},        '{12000, -35000, 37000}, '{30000, -40000, 50000},
    '{-20000, 21000, 29000}, '{46340, 46340, 65535}, '{65535, 0, 65535},
    '{0, -65536, 65536},   '{-65536, -65536, 92682}, '{-65536, 65535, 92681},
    '{-65536, -20000, 68520}
  };

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   in_valid = 1'b0;
  logic signed [IN_W-1:0] in_i = '0;
  logic signed [IN_W-1:0] in_q = '0;
  logic [TAG_W-1:0]       in_tag = '0;
  logic                   out_valid;
  logic [OUT_W-1:0]       out_mag;
  logic [TAG_W-1:0]       out_tag;

  cordmag_top i_cordmag_top (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q), .in_tag(in_tag),
    .out_valid(out_valid), .out_mag(out_mag), .out_tag(out_tag)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  int n_sent = 0, n_got = 0;
  int exp_m [NTAG];
  int iss   [NTAG];
  bit pend  [NTAG];
  int next_tag = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int ref_mag(input int vi, input int vq);
    real r;
    r = $sqrt(real'(vi) * real'(vi) + real'(vq) * real'(vq));
    return $rtoi(r + 0.5);
  endfunction

  task automatic send(input int vi, input int vq, input int e);
    @(negedge clk);
    in_valid = 1'b1;
    in_i     = IN_W'(vi);
    in_q     = IN_W'(vq);
    in_tag   = TAG_W'(next_tag);
    exp_m[next_tag] = e;
    iss[next_tag]   = cyc;
    pend[next_tag]  = 1'b1;
    next_tag = (next_tag + 1) % NTAG;
    n_sent++;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_i     = '0;
    in_q     = '0;
  endtask

  // Result monitor: matches every result to its sample by tag.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      automatic int t = int'(out_tag);
      automatic int e = exp_m[t];
      automatic int a = int'(out_mag);
      automatic int lim = (e > MAXV) ? MAXV : e;
      n_got++;
      check(pend[t], "R4", "result tag without pending sample", t, -1);
      if (pend[t]) begin
        pend[t] = 1'b0;
        check(cyc - iss[t] == LAT, "R3", "latency", cyc - iss[t], LAT);
        if (e >= MAXV + 2)
          check(a == MAXV, "R2", "clamped magnitude", a, MAXV);
        else if (e == 0)
          check(a == 0, "R7", "zero vector magnitude", a, 0);
        else
          check((a - lim <= 2) && (lim - a <= 2), "R1", "magnitude", a, lim);
      end
    end
  end

  initial begin
    for (int k = 0; k < NTAG; k++) begin
      pend[k] = 1'b0; exp_m[k] = 0; iss[k] = 0;
    end
    repeat (3) @(negedge clk);
    check(!out_valid && out_mag == '0 && out_tag == '0, "R6",
          "outputs during reset", {out_valid, out_mag, out_tag}, 0);
    rst = 1'b0;

    // Table walk, back to back.
    for (int v = 0; v < NVEC; v++) send(VEC[v][0], VEC[v][1], VEC[v][2]);
    idle();
    repeat (LAT + 4) idle();

    // Continuous random stream, one sample per clock (R5).
    for (int n = 0; n < 300; n++) begin
      automatic int vi = int'($urandom % 131072) - 65536;
      automatic int vq = int'($urandom % 131072) - 65536;
      send(vi, vq, ref_mag(vi, vq));
    end
    // Random stream with gaps; small vectors too (R1, R5).
    for (int n = 0; n < 300; n++) begin
      automatic int sh = int'($urandom % 17);
      automatic int vi = (int'($urandom % 131072) - 65536) >>> sh;
      automatic int vq = (int'($urandom % 131072) - 65536) >>> sh;
      if ($urandom % 4 == 0) idle();
      else send(vi, vq, ref_mag(vi, vq));
    end
    repeat (LAT + 4) idle();
    check(n_got == n_sent, "R5", "results versus accepted samples",
          n_got, n_sent);

    // Reset with samples in flight (R6).
    for (int n = 0; n < 6; n++) send(1000 * (n + 1), -500, ref_mag(1000 * (n + 1), -500));
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(!out_valid && out_mag == '0 && out_tag == '0, "R6",
          "outputs after reset edge", {out_valid, out_mag, out_tag}, 0);
    rst = 1'b0;
    for (int k = 0; k < NTAG; k++) pend[k] = 1'b0;
    begin
      automatic int stray = 0;
      for (int n = 0; n < LAT + 3; n++) begin
        @(negedge clk);
        if (out_valid) stray++;
      end
      check(stray == 0, "R6", "results from discarded samples", stray, 0);
    end

    // Stream resumes cleanly after reset.
    send(-3, -4, 5);
    send(0, 0, 0);
    repeat (LAT + 4) idle();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule